// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line interrupt resolvers into a sixteen-line controller. The upper resolver (the "secondary", lines 8 to 15) reports into line 2 of the lower resolver (the "primary", lines 0 to 7). Line 2 of the primary has no external pin. A single CPU interrupt output is raised whenever the primary has a request that is allowed to interrupt. A one-cycle acknowledge strobe then selects the winning line, marks it in service and returns an 8-bit vector.

Each resolver has its own vector base, request mask, in-service set and trigger-mode register. All of them are reached over a byte-wide register bus that claims six addresses and ignores all others. Wider accesses are ignored. Command decoding inside each resolver is kept to a minimum:
- writing the even address loads the vector base and clears the in-service set;
- writing the odd address loads the mask.

Top module: `pic_cascade_ack`

## Requirements
- R1: Addresses 0x0020/0x0021 reach the primary and 0x00A0/0x00A1 the secondary (even: base write and in-service read; odd: mask write and request read). 0x04D0 and 0x04D1 are the primary and secondary trigger-mode registers. Any other address is ignored, and reads of it return 0.
- R2: An access whose `acc_bytes` is not 1 changes no state, and its read data is 0.
- R3: A trigger-mode write stores `wdata & 0xF8` on the primary and `wdata & 0xDE` on the secondary. A read returns the stored value. A set bit selects level mode for that line.
- R4: A base write keeps `wdata[7:3]` as the vector base, with the low three vector bits supplied by the line number, and clears that resolver's in-service set.
- R5: In edge mode a request latches on a rising edge of its line and is held until acknowledged. In level mode the request follows the line. A masked request cannot win.
- R6: Lower line numbers have higher priority. A pending request wins only if its line is numbered below every in-service line.
- R7: While the secondary has a winner, primary request bit 2 is set on the next clock. The external pin `req[2]` has no effect.
- R8: On acknowledge, the primary winner's in-service bit is set. Its request bit is cleared in edge mode and kept in level mode. If the winner is not line 2, the vector is the primary base plus the line.
- R9: If the primary winner is line 2, the secondary winner is also taken into service. The vector is then the secondary base plus its line.
- R10: If the primary winner is line 2 but the secondary has no winner, the vector is the secondary base plus 7, and no secondary in-service bit is set.
- R11: If the primary has no winner at acknowledge, the vector is the primary base plus 7.
- R12: `vec_vld` is high exactly on the cycle after an `ack` cycle, and `vec` is held with it.
- R13: `int_out` is high whenever the primary has a winner, and it is updated after each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 16 | Request lines; bits 7:0 go to the primary, bits 15:8 to the secondary |
| ack | input | 1 | One-cycle acknowledge strobe |
| addr | input | 16 | Register bus address |
| wdata | input | 8 | Write data |
| acc_bytes | input | 3 | Access width in bytes; only 1 is acted on |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | 8 | Read data, combinational |
| int_out | output | 1 | CPU interrupt line |
| vec | output | 8 | Vector of the last acknowledge |
| vec_vld | output | 1 | Vector valid on the cycle after acknowledge |

## Verification
The following are checked on every cycle by assertions:
- the strobe-to-valid timing;
- the primary-spurious vector;
- cascade propagation into primary bit 2;
- trigger-mask storage;
- the in-service update after a granted acknowledge.

Only the bench scenarios can show the rest: the full vector arithmetic for every line of both resolvers, the spurious-secondary path built from a vanished level request, and priority nesting and preemption against the in-service set. The same holds for the decode and width filters, which are shown through later reads and vectors.

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack #(
  parameter logic [15:0] MST_PORT     = 16'h0020,
  parameter logic [15:0] SLV_PORT     = 16'h00A0,
  parameter logic [15:0] TRG_PORT     = 16'h04D0,
  parameter logic [7:0]  MST_TRG_MASK = 8'hF8,
  parameter logic [7:0]  SLV_TRG_MASK = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] req,
  input  logic        ack,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic [2:0]  acc_bytes,
  input  logic        we,
  input  logic        re,
  output logic [7:0]  rdata,
  output logic        int_out,
  output logic [7:0]  vec,
  output logic        vec_vld
);

  function automatic logic [3:0] first_set(input logic [7:0] v);
    logic [3:0] r;
    r = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) r = 4'(i);
    return r;
  endfunction

  logic [7:0] irr_m, irr_s, isr_m, isr_s, imr_m, imr_s, trg_m, trg_s, prev_m, prev_s;
  logic [4:0] base_m, base_s;
  logic [7:0] vec_q;
  logic       vld_q;

  logic byte_ok, hit_m, hit_s, hit_t, wr_ok, rd_ok;
  assign byte_ok = (acc_bytes == 3'd1);
  assign hit_m   = (addr[15:1] == MST_PORT[15:1]);
  assign hit_s   = (addr[15:1] == SLV_PORT[15:1]);
  assign hit_t   = (addr[15:1] == TRG_PORT[15:1]);
  assign wr_ok   = we && byte_ok;
  assign rd_ok   = re && byte_ok;

  logic wr_base_m, wr_imr_m, wr_base_s, wr_imr_s, wr_trg_m, wr_trg_s;
  assign wr_base_m = wr_ok && hit_m && !addr[0];
  assign wr_imr_m  = wr_ok && hit_m &&  addr[0];
  assign wr_base_s = wr_ok && hit_s && !addr[0];
  assign wr_imr_s  = wr_ok && hit_s &&  addr[0];
  assign wr_trg_m  = wr_ok && hit_t && !addr[0];
  assign wr_trg_s  = wr_ok && hit_t &&  addr[0];

  logic [3:0] m_pick, m_cur, s_pick, s_cur;
  logic       m_ok, s_ok;
  logic [2:0] m_line, s_line;
  assign m_pick = first_set(irr_m & ~imr_m);
  assign m_cur  = first_set(isr_m);
  assign s_pick = first_set(irr_s & ~imr_s);
  assign s_cur  = first_set(isr_s);
  assign m_ok   = (m_pick < m_cur);
  assign s_ok   = (s_pick < s_cur);
  assign m_line = m_pick[2:0];
  assign s_line = s_pick[2:0];

  logic       thru;
  logic [7:0] take_m, take_s;
  assign thru   = ack && m_ok && (m_line == 3'd2);
  assign take_m = (ack && m_ok) ? (8'd1 << m_line) : 8'd0;
  assign take_s = (thru && s_ok) ? (8'd1 << s_line) : 8'd0;

  logic [7:0] raw_m, raw_s, set_m, set_s, irr_m_n, irr_s_n;
  assign raw_m   = {req[7:3], 1'b0, req[1:0]};
  assign raw_s   = req[15:8];
  assign set_m   = (raw_m & ~prev_m) | (s_ok ? 8'h04 : 8'h00);
  assign set_s   = raw_s & ~prev_s;
  assign irr_m_n = (((irr_m | set_m) & ~trg_m) | (raw_m & trg_m)) & ~(take_m & ~trg_m);
  assign irr_s_n = (((irr_s | set_s) & ~trg_s) | (raw_s & trg_s)) & ~(take_s & ~trg_s);

  logic [7:0] vec_n;
  always_comb begin
    if (!m_ok)              vec_n = {base_m, 3'd7};
    else if (m_line != 3'd2) vec_n = {base_m, m_line};
    else if (s_ok)          vec_n = {base_s, s_line};
    else                    vec_n = {base_s, 3'd7};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_m <= '0; irr_s <= '0; isr_m <= '0; isr_s <= '0;
      imr_m <= '0; imr_s <= '0; trg_m <= '0; trg_s <= '0;
      prev_m <= '0; prev_s <= '0; base_m <= '0; base_s <= '0;
      vec_q <= '0; vld_q <= 1'b0;
    end else begin
      prev_m <= raw_m;
      prev_s <= raw_s;
      irr_m  <= irr_m_n;
      irr_s  <= irr_s_n;
      isr_m  <= wr_base_m ? 8'h00 : (isr_m | take_m);
      isr_s  <= wr_base_s ? 8'h00 : (isr_s | take_s);
      if (wr_base_m) base_m <= wdata[7:3];
      if (wr_base_s) base_s <= wdata[7:3];
      if (wr_imr_m)  imr_m  <= wdata;
      if (wr_imr_s)  imr_s  <= wdata;
      if (wr_trg_m)  trg_m  <= wdata & MST_TRG_MASK;
      if (wr_trg_s)  trg_s  <= wdata & SLV_TRG_MASK;
      vld_q <= ack;
      if (ack) vec_q <= vec_n;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_ok) begin
      if (hit_m)      rdata = addr[0] ? irr_m : isr_m;
      else if (hit_s) rdata = addr[0] ? irr_s : isr_s;
      else if (hit_t) rdata = addr[0] ? trg_s : trg_m;
    end
  end

  assign int_out = m_ok;
  assign vec     = vec_q;
  assign vec_vld = vld_q;

  a_r12_vec_strobe: assert property (@(posedge clk) disable iff (!rst_n) ack |=> vec_vld);
  a_r12_no_vec: assert property (@(posedge clk) disable iff (!rst_n) !ack |=> !vec_vld);
  a_r11_spur_master: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out) |=> (vec == {$past(base_m), 3'd7}));
  a_r7_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ok && !ack) |=> irr_m[2]);
  a_r3_trg_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trg_s |=> (trg_s == ($past(wdata) & SLV_TRG_MASK)));
  a_r8_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !wr_base_m) |=> (isr_m != 8'h00));

endmodule

// File: tb/pic_cascade_ack_test.sv
module pic_cascade_ack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        ack = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  acc_bytes = 3'd1;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  rdata;
  logic        int_out;
  logic [7:0]  vec;
  logic        vec_vld;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  pic_cascade_ack uut (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .addr(addr), .wdata(wdata),
    .acc_bytes(acc_bytes), .we(we), .re(re), .rdata(rdata), .int_out(int_out),
    .vec(vec), .vec_vld(vec_vld)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] n = 3'd1);
    @(negedge clk);
    addr = a; wdata = d; acc_bytes = n; we = 1'b1;
    @(negedge clk);
    we = 1'b0; acc_bytes = 3'd1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] n = 3'd1);
    @(negedge clk);
    addr = a; acc_bytes = n; re = 1'b1;
    #1 rv = rdata;
    re = 1'b0; acc_bytes = 3'd1;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    #1;
  endtask

  task automatic setreq(input logic [15:0] v);
    @(negedge clk);
    req = v;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R13 reset int_out", int_out, 0);
    chk("R12 reset vec_vld", vec_vld, 0);
    rd(16'h0020); chk("R1 reset primary in-service", rv, 0);
    rd(16'h04D0); chk("R3 reset primary trigger", rv, 0);

    for (int v = 0; v < 256; v++) begin
      wr(16'h04D0, 8'(v)); rd(16'h04D0); chk("R3 primary trigger mask", rv, v & 8'hF8);
      wr(16'h04D1, 8'(v)); rd(16'h04D1); chk("R3 secondary trigger mask", rv, v & 8'hDE);
    end
    wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h00);

    for (int v = 0; v < 32; v++) begin
      logic [7:0] b;
      b = 8'(v * 8 + (v % 8));
      wr(16'h0020, b);
      do_ack();
      chk("R12 vec_vld after ack", vec_vld, 1);
      chk("R11 R4 spurious primary vector", vec, (b & 8'hF8) | 8'h07);
    end
    waitc(1);
    chk("R12 vec_vld drops", vec_vld, 0);

    for (int i = 0; i < 8; i++) begin
      if (i == 2) continue;
      wr(16'h0020, 8'h40);
      setreq(16'(1 << i)); waitc(1);
      chk("R13 int_out on primary request", int_out, 1);
      do_ack();
      chk("R8 primary vector", vec, 8'h40 + i);
      rd(16'h0020); chk("R8 primary in-service", rv, 1 << i);
      rd(16'h0021); chk("R8 edge request cleared", rv, 0);
      setreq(16'h0000); waitc(1);
      chk("R13 int_out after ack", int_out, 0);
    end

    for (int i = 0; i < 8; i++) begin
      wr(16'h0020, 8'h40); wr(16'h00A0, 8'h70);
      setreq(16'(1 << (8 + i))); waitc(2);
      chk("R7 cascade raises int_out", int_out, 1);
      do_ack();
      chk("R9 secondary vector", vec, 8'h70 + i);
      rd(16'h00A0); chk("R9 secondary in-service", rv, 1 << i);
      rd(16'h0020); chk("R9 primary line 2 in service", rv, 8'h04);
      rd(16'h0021); chk("R7 primary bit 2 cleared", rv, 0);
      setreq(16'h0000);
    end
    wr(16'h00A0, 8'h70);

    wr(16'h0020, 8'h40);
    setreq(16'h0004); waitc(2);
    chk("R7 req[2] ignored int_out", int_out, 0);
    rd(16'h0021); chk("R7 req[2] ignored request", rv, 0);
    setreq(16'h0000);

    wr(16'h0021, 8'h08);
    setreq(16'h0008); waitc(1);
    chk("R5 masked request", int_out, 0);
    wr(16'h0021, 8'h00); #1;
    chk("R5 unmasked request", int_out, 1);
    do_ack(); chk("R5 vector after unmask", vec, 8'h43);
    setreq(16'h0000);

    wr(16'h0020, 8'h40);
    setreq(16'h0022); waitc(1);
    do_ack(); chk("R6 higher priority first", vec, 8'h41);
    setreq(16'h0000); waitc(1);
    chk("R6 lower blocked by in-service", int_out, 0);
    wr(16'h0020, 8'h40); #1;
    chk("R6 unblocked after clear", int_out, 1);
    do_ack(); chk("R6 second vector", vec, 8'h45);
    setreq(16'h0001); waitc(1);
    chk("R6 preempt over in-service", int_out, 1);
    do_ack(); chk("R6 preempt vector", vec, 8'h40);
    setreq(16'h0000);

    wr(16'h04D0, 8'h08); wr(16'h0020, 8'h40);
    setreq(16'h0008); waitc(1);
    do_ack(); chk("R8 level vector", vec, 8'h43);
    rd(16'h0021); chk("R5 level request held", rv, 8'h08);
    setreq(16'h0000); waitc(1);
    rd(16'h0021); chk("R5 level request follows line", rv, 0);
    wr(16'h04D0, 8'h00);

    wr(16'h0020, 8'h40); wr(16'h00A0, 8'h70); wr(16'h04D1, 8'h02);
    setreq(16'h0200); waitc(3);
    setreq(16'h0000); waitc(3);
    chk("R10 primary line 2 still pending", int_out, 1);
    do_ack(); chk("R10 spurious secondary vector", vec, 8'h77);
    rd(16'h00A0); chk("R10 no secondary in-service", rv, 0);
    rd(16'h0020); chk("R10 primary line 2 in service", rv, 8'h04);
    wr(16'h04D1, 8'h00);

    wr(16'h0020, 8'h40);
    wr(16'h0020, 8'h99, 3'd2);
    do_ack(); chk("R2 wide base write ignored", vec, 8'h47);
    wr(16'h04D0, 8'hFF, 3'd4);
    rd(16'h04D0); chk("R2 wide trigger write ignored", rv, 0);
    wr(16'h04D0, 8'hF8);
    rd(16'h04D0, 3'd2); chk("R2 wide read returns 0", rv, 0);
    wr(16'h04D0, 8'h00);
    wr(16'h04D2, 8'hFF);
    rd(16'h04D0); chk("R1 unclaimed write primary trigger", rv, 0);
    rd(16'h04D1); chk("R1 unclaimed write secondary trigger", rv, 0);
    wr(16'h0120, 8'h55);
    do_ack(); chk("R1 unclaimed base write", vec, 8'h47);
    wr(16'h0022, 8'h10);
    rd(16'h0022); chk("R1 unclaimed read", rv, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule